// File: doc/BRIEF.md
# Two-Way Data Cache Controller with Selectable Write Policy

The block is a small data cache controller. It sits between a processor port that carries one word per access and a memory port that moves whole lines. The cache is two-way set-associative. Each line holds a valid flag, a modified flag, a tag and a block of several words. One bit per set records which of the two ways was used least recently, and that way is the victim on a miss.

A mode input selects the write policy at run time. In write-back mode, writes stay in the cache and mark the line modified. A write miss allocates the line. In write-through mode, every write also goes straight to memory as a single-word write with a lane mask. A write miss does not allocate a line, and no line is ever marked modified. The controller latches the mode when it accepts each access.

Two whole-cache commands exist. The discard command drops every line and writes nothing to memory. The flush command walks every set and way and writes each modified line back to memory, then drops every line. While either command runs, the busy output is high and processor requests wait.

Top module: `cache_wp_ctrl`

## Requirements
- R1: After reset every line is invalid, write-back mode is in force, and busy, cpu_ready and mem_req are all low. The first read issues a memory fetch.
- R2: The set is word address bits [OFF_W+IDX_W-1:OFF_W], which is the block number modulo the set count. The tag is the bits above the set. Two blocks with the same set and different tags are held at the same time, and at most one way matches a lookup.
- R3: A read miss fetches the whole line with one memory read, where mem_addr is the word address shifted right by OFF_W. Word i of a line occupies bits [i*DATA_W +: DATA_W] of the line buses. Later reads of other words in that line cause no memory traffic.
- R4: A miss to a set whose two ways are both valid replaces the way used least recently. Hits and fills both count as uses. An invalid way is filled first, way 0 before way 1.
- R5: In write-back mode a write hit updates only the cache and marks the line modified. A write miss first fetches the line (allocate) and then writes into it. Memory keeps its old value.
- R6: Before a victim is refilled, a modified victim is written to its own block address as a full line with mem_wmask all ones. An unmodified victim causes no memory write.
- R7: In write-through mode each write is one memory write with exactly one mem_wmask bit set, at the word offset, and the word is in that lane. A hit also updates the cached copy. A miss does not allocate. No line becomes modified, so a later eviction of that line writes nothing back.
- R8: The discard command clears every valid flag with no memory traffic. Modified data is lost, and later reads fetch from memory.
- R9: The flush command writes every valid modified line as a full line, in ascending order of the index {set, way}. It skips clean lines and then clears every valid flag.
- R10: busy is high while a command runs, and cpu_ready stays low throughout. Commands are taken only between accesses. A flush request wins over a processor request raised in the same cycle, and that request is served after the flush.
- R11: The processor holds cpu_valid, cpu_we, cpu_addr and cpu_wdata until cpu_ready rises for exactly one cycle, with the read word on cpu_rdata in that cycle. mem_req and mem_addr hold steady until mem_ack, and mem_rline is valid during the cycle of mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| cmd_inval | input | 1 | Request to discard all lines |
| cmd_flush | input | 1 | Request to write back modified lines, then discard all |
| busy | output | 1 | A whole-cache command is running |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | BLK_W | Line (block) address |
| mem_wmask | output | LINE_WORDS | Per-word write enables |
| mem_wline | output | LINE_W | Write line, word i in lane i |
| mem_ack | input | 1 | Transfer complete |
| mem_rline | input | LINE_W | Fetched line, valid with mem_ack |

## Verification
The bench aims at the points where the write policy and victim choice are easy to get wrong.
- **Least-recently-used choice:** a victim picked without updating the use bit on hits would evict the line that was just touched. A later read of that line would then show an unexpected fetch.
- **Modified-bit handling across a mode switch:** a design that marked lines modified in write-through mode would write the line back when it is evicted. A design that never wrote dirty victims back would leave stale memory.
- **Discard versus flush:** the two commands differ only in whether modified lines reach memory. The bench holds a processor read pending during the flush to check that busy blocks it and that the write-backs come out in ascending {set, way} order.
- **Write miss under each policy:** a design that allocated on write-through misses would show no fetch on the following read.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int NUM_SETS   = 4;
    localparam int NUM_WAYS   = 2;

    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_WORDS * DATA_W;
    localparam int PTR_W  = IDX_W + WAY_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic vld;
        logic dty;
        tag_t tag;
    } meta_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP,
        ST_FLUSH,
        ST_INVAL
    } state_t;

    function automatic tag_t addr_tag(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic idx_t addr_idx(logic [ADDR_W-1:0] a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic off_t addr_off(logic [ADDR_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

    function automatic word_t get_word(line_t ln, off_t o);
        word_t r = '0;
        for (int i = 0; i < LINE_WORDS; i++)
            if (o == off_t'(i)) r = ln[i*DATA_W +: DATA_W];
        return r;
    endfunction

    function automatic line_t put_word(line_t ln, off_t o, word_t w);
        line_t r = ln;
        for (int i = 0; i < LINE_WORDS; i++)
            if (o == off_t'(i)) r[i*DATA_W +: DATA_W] = w;
        return r;
    endfunction

    function automatic logic [LINE_WORDS-1:0] lane_mask(off_t o);
        logic [LINE_WORDS-1:0] m = '0;
        for (int i = 0; i < LINE_WORDS; i++)
            m[i] = (o == off_t'(i));
        return m;
    endfunction

endpackage

// File: rtl/wpc_meta.sv
module wpc_meta
    import wpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  idx_t                idx,
    input  tag_t                look_tag,
    output meta_t               way_meta [NUM_WAYS],
    output logic [NUM_WAYS-1:0] hit_vec,
    output way_t                lru_way,
    input  logic                wr_en,
    input  way_t                wr_way,
    input  meta_t               wr_meta,
    input  logic                touch_en,
    input  way_t                touch_way,
    input  logic                clr_all
);

    meta_t meta_q [NUM_SETS][NUM_WAYS];
    way_t  lru_q  [NUM_SETS];
    logic  any_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                lru_q[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++)
                    meta_q[s][w] <= '0;
            end
        end else begin
            if (clr_all) begin
                for (int s = 0; s < NUM_SETS; s++)
                    for (int w = 0; w < NUM_WAYS; w++) begin
                        meta_q[s][w].vld <= 1'b0;
                        meta_q[s][w].dty <= 1'b0;
                    end
            end else if (wr_en) begin
                meta_q[idx][wr_way] <= wr_meta;
            end
            if (touch_en)
                lru_q[idx] <= ~touch_way;
        end
    end

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            assign way_meta[w] = meta_q[idx][w];
            assign hit_vec[w]  = meta_q[idx][w].vld && (meta_q[idx][w].tag == look_tag);

            // R5: a modified line is always a valid line
            assert_dirty_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
                way_meta[w].dty |-> way_meta[w].vld);
        end
    endgenerate

    assign lru_way = lru_q[idx];

    always_comb begin
        any_vld = 1'b0;
        for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
                any_vld = any_vld | meta_q[s][w].vld;
    end

    assert_single_hit_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_vec) <= 1);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> !any_vld);

endmodule

// File: rtl/wpc_data.sv
module wpc_data
    import wpc_pkg::*;
(
    input  logic  clk,
    input  idx_t  idx,
    output line_t rd_line [NUM_WAYS],
    input  logic  word_we,
    input  logic  line_we,
    input  way_t  way,
    input  off_t  off,
    input  word_t word_in,
    input  line_t line_in
);

    line_t data_q [NUM_SETS][NUM_WAYS];

    always_ff @(posedge clk) begin
        if (line_we)
            data_q[idx][way] <= line_in;
        else if (word_we)
            data_q[idx][way] <= put_word(data_q[idx][way], off, word_in);
    end

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
            assign rd_line[w] = data_q[idx][w];
        end
    endgenerate

endmodule

// File: rtl/cache_wp_ctrl.sv
module cache_wp_ctrl
    import wpc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wt_mode,
    input  logic                  cmd_inval,
    input  logic                  cmd_flush,
    output logic                  busy,
    input  logic                  cpu_valid,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [BLK_W-1:0]      mem_addr,
    output logic [LINE_WORDS-1:0] mem_wmask,
    output logic [LINE_W-1:0]     mem_wline,
    input  logic                  mem_ack,
    input  logic [LINE_W-1:0]     mem_rline
);

    state_t              state_q, state_d;
    logic                req_we_q, wt_q;
    logic [ADDR_W-1:0]   req_addr_q;
    word_t               req_wdata_q, rdata_q;
    way_t                vict_q;
    logic [PTR_W-1:0]    fl_ptr_q;

    tag_t  req_tag;
    idx_t  req_idx, fl_set, cur_idx;
    off_t  req_off;
    way_t  fl_way, hit_way, victim;
    logic  hit, fl_need, advance;

    meta_t               way_meta [NUM_WAYS];
    logic [NUM_WAYS-1:0] hit_vec;
    way_t                lru_way;
    line_t               rd_line [NUM_WAYS];

    logic  meta_wr, touch, clr, dword_we, dline_we;
    way_t  meta_way, touch_way, data_way;
    meta_t meta_new;

    assign req_tag = addr_tag(req_addr_q);
    assign req_idx = addr_idx(req_addr_q);
    assign req_off = addr_off(req_addr_q);
    assign fl_set  = fl_ptr_q[PTR_W-1 -: IDX_W];
    assign fl_way  = fl_ptr_q[WAY_W-1:0];
    assign cur_idx = (state_q == ST_FLUSH) ? fl_set : req_idx;

    wpc_meta u_meta (
        .clk       (clk),
        .rst       (rst),
        .idx       (cur_idx),
        .look_tag  (req_tag),
        .way_meta  (way_meta),
        .hit_vec   (hit_vec),
        .lru_way   (lru_way),
        .wr_en     (meta_wr),
        .wr_way    (meta_way),
        .wr_meta   (meta_new),
        .touch_en  (touch),
        .touch_way (touch_way),
        .clr_all   (clr)
    );

    wpc_data u_data (
        .clk     (clk),
        .idx     (cur_idx),
        .rd_line (rd_line),
        .word_we (dword_we),
        .line_we (dline_we),
        .way     (data_way),
        .off     (req_off),
        .word_in (req_wdata_q),
        .line_in (mem_rline)
    );

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];
    assign victim  = !way_meta[0].vld ? way_t'(0) :
                     !way_meta[1].vld ? way_t'(1) : lru_way;
    assign fl_need = way_meta[fl_way].vld && way_meta[fl_way].dty;

    always_comb begin
        state_d   = state_q;
        meta_wr   = 1'b0;
        meta_way  = '0;
        meta_new  = '0;
        touch     = 1'b0;
        touch_way = '0;
        clr       = 1'b0;
        dword_we  = 1'b0;
        dline_we  = 1'b0;
        data_way  = '0;
        advance   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_flush)      state_d = ST_FLUSH;
                else if (cmd_inval) state_d = ST_INVAL;
                else if (cpu_valid) state_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (hit) begin
                    touch     = 1'b1;
                    touch_way = hit_way;
                    if (req_we_q) begin
                        dword_we = 1'b1;
                        data_way = hit_way;
                        if (!wt_q) begin
                            meta_wr  = 1'b1;
                            meta_way = hit_way;
                            meta_new = '{vld: 1'b1, dty: 1'b1, tag: req_tag};
                        end
                        state_d = wt_q ? ST_WTHRU : ST_RESP;
                    end else begin
                        state_d = ST_RESP;
                    end
                end else if (req_we_q && wt_q) begin
                    state_d = ST_WTHRU;
                end else begin
                    state_d = (way_meta[victim].vld && way_meta[victim].dty) ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: if (mem_ack) state_d = ST_FILL;
            ST_FILL: begin
                if (mem_ack) begin
                    dline_we  = 1'b1;
                    data_way  = vict_q;
                    meta_wr   = 1'b1;
                    meta_way  = vict_q;
                    meta_new  = '{vld: 1'b1, dty: 1'b0, tag: req_tag};
                    touch     = 1'b1;
                    touch_way = vict_q;
                    state_d   = ST_LOOK;
                end
            end
            ST_WTHRU: if (mem_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_FLUSH: begin
                if (fl_need) begin
                    if (mem_ack) begin
                        meta_wr  = 1'b1;
                        meta_way = fl_way;
                        meta_new = '{vld: 1'b1, dty: 1'b0, tag: way_meta[fl_way].tag};
                        advance  = 1'b1;
                    end
                end else begin
                    advance = 1'b1;
                end
                if (advance && (fl_ptr_q == '1)) begin
                    clr     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_INVAL: begin
                clr     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_we_q    <= 1'b0;
            wt_q        <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            vict_q      <= '0;
            fl_ptr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                fl_ptr_q <= '0;
                if (cpu_valid && !cmd_flush && !cmd_inval) begin
                    req_we_q    <= cpu_we;
                    req_addr_q  <= cpu_addr;
                    req_wdata_q <= cpu_wdata;
                    wt_q        <= wt_mode;
                end
            end
            if (state_q == ST_LOOK) begin
                if (hit) rdata_q <= get_word(rd_line[hit_way], req_off);
                else     vict_q  <= victim;
            end
            if (state_q == ST_FLUSH && advance)
                fl_ptr_q <= fl_ptr_q + 1'b1;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr_q[ADDR_W-1:OFF_W];
        mem_wmask = '1;
        mem_wline = '0;
        case (state_q)
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {way_meta[vict_q].tag, req_idx};
                mem_wline = rd_line[vict_q];
            end
            ST_FILL: mem_req = 1'b1;
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wmask = lane_mask(req_off);
                mem_wline = {LINE_WORDS{req_wdata_q}};
            end
            ST_FLUSH: begin
                mem_req   = fl_need;
                mem_we    = 1'b1;
                mem_addr  = {way_meta[fl_way].tag, fl_set};
                mem_wline = rd_line[fl_way];
            end
            default: ;
        endcase
    end

    assign busy      = (state_q == ST_FLUSH) || (state_q == ST_INVAL);
    assign cpu_ready = (state_q == ST_RESP);
    assign cpu_rdata = rdata_q;

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_busy_blocks_cpu_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cpu_ready);

    assert_word_write_only_wt_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && (mem_wmask != '1)) |-> (wt_q && ($countones(mem_wmask) == 1)));

    assert_evict_only_dirty_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVICT) |-> (way_meta[vict_q].vld && way_meta[vict_q].dty));

    assert_flush_ascends_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH && $past(state_q) == ST_FLUSH) |-> (fl_ptr_q >= $past(fl_ptr_q)));

endmodule

// File: tb/sim_cache_wp_ctrl.sv
`timescale 1ns/1ps
module sim_cache_wp_ctrl;
    import wpc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wt_mode = 1'b0, cmd_inval = 1'b0, cmd_flush = 1'b0;
    logic busy;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [BLK_W-1:0] mem_addr;
    logic [LINE_WORDS-1:0] mem_wmask;
    logic [LINE_W-1:0] mem_wline;
    logic mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rline = '0;

    always #2 clk = ~clk;

    cache_wp_ctrl u0 (
        .clk(clk), .rst(rst), .wt_mode(wt_mode), .cmd_inval(cmd_inval),
        .cmd_flush(cmd_flush), .busy(busy), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wmask(mem_wmask), .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline)
    );

    localparam int MEM_WORDS = 1 << ADDR_W;
    logic [DATA_W-1:0] memw [MEM_WORDS];
    logic [DATA_W-1:0] expw [MEM_WORDS];

    int n_chk = 0, n_bad = 0, n_tx = 0;
    logic                  lg_we   [64];
    logic [BLK_W-1:0]      lg_addr [64];
    logic [LINE_WORDS-1:0] lg_mask [64];

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            memw[i] = 32'hC0DE_0000 + i;
            expw[i] = 32'hC0DE_0000 + i;
        end
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (n_tx < 64) begin
                    lg_we[n_tx]   = mem_we;
                    lg_addr[n_tx] = mem_addr;
                    lg_mask[n_tx] = mem_wmask;
                end
                n_tx++;
                for (int w = 0; w < LINE_WORDS; w++) begin
                    if (mem_we && mem_wmask[w])
                        memw[int'(mem_addr) * LINE_WORDS + w] = mem_wline[w*DATA_W +: DATA_W];
                    mem_rline[w*DATA_W +: DATA_W] = memw[int'(mem_addr) * LINE_WORDS + w];
                end
                mem_ack = 1'b1;
            end
        end
    end

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int o);
        return {TAG_W'(t), IDX_W'(s), OFF_W'(o)};
    endfunction

    function automatic logic [BLK_W-1:0] blk(int t, int s);
        return {TAG_W'(t), IDX_W'(s)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 1000 && !cpu_ready; i++) @(negedge clk);
        rd = cpu_rdata;
        cpu_valid = 1'b0;
        if (we) expw[a] = wd;
    endtask

    task automatic rd_expect(input string req, input logic [ADDR_W-1:0] a, input int txs);
        logic [31:0] rd;
        n_tx = 0;
        access(1'b0, a, '0, rd);
        chk({req, " read data"}, rd, expw[a]);
        chk({req, " memory transfers"}, n_tx, txs);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 cpu_ready after reset", cpu_ready, 0);
        chk("R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_fill;
        rd_expect("R1 R3 first read miss", mk(1,1,1), 1);
        chk("R3 fetch is a read", lg_we[0], 0);
        chk("R3 fetch block address", lg_addr[0], blk(1,1));
        rd_expect("R3 same line word 3", mk(1,1,3), 0);
        rd_expect("R11 same line word 0", mk(1,1,0), 0);
    endtask

    task automatic t_map;
        rd_expect("R2 second tag same set", mk(2,1,0), 1);
        rd_expect("R2 first tag still held", mk(1,1,2), 0);
        rd_expect("R2 other set", mk(1,2,0), 1);
        rd_expect("R2 both ways held", mk(2,1,0), 0);
    endtask

    task automatic t_lru;
        rd_expect("R4 touch way0", mk(1,1,1), 0);
        rd_expect("R4 third tag miss", mk(3,1,0), 1);
        rd_expect("R4 recent line kept", mk(1,1,0), 0);
        rd_expect("R4 lru line evicted", mk(2,1,0), 1);
    endtask

    task automatic t_wb;
        logic [31:0] rd;
        n_tx = 0;
        access(1'b1, mk(4,3,1), 32'hAAAA_0001, rd);
        chk("R5 write miss allocates", n_tx, 1);
        chk("R5 allocate is a read", lg_we[0], 0);
        n_tx = 0;
        access(1'b1, mk(4,3,2), 32'hAAAA_0002, rd);
        chk("R5 write hit no traffic", n_tx, 0);
        chk("R5 memory unchanged", memw[mk(4,3,1)], 32'hC0DE_0000 + mk(4,3,1));
        rd_expect("R5 read back", mk(4,3,1), 0);
        rd_expect("R6 fill other way", mk(5,3,0), 1);
        rd_expect("R6 dirty victim", mk(6,3,0), 2);
        chk("R6 write-back first", lg_we[0], 1);
        chk("R6 write-back address", lg_addr[0], blk(4,3));
        chk("R6 full line mask", lg_mask[0], 4'hF);
        chk("R6 refill after", lg_we[1], 0);
        chk("R6 memory word1", memw[mk(4,3,1)], 32'hAAAA_0001);
        chk("R6 memory word2", memw[mk(4,3,2)], 32'hAAAA_0002);
        rd_expect("R6 clean victim", mk(7,3,0), 1);
        chk("R6 clean victim no write", lg_we[0], 0);
    endtask

    task automatic t_wt;
        logic [31:0] rd;
        @(negedge clk); wt_mode = 1'b1;
        n_tx = 0;
        access(1'b1, mk(7,3,2), 32'hBBBB_0001, rd);
        chk("R7 hit sends one write", n_tx, 1);
        chk("R7 is write", lg_we[0], 1);
        chk("R7 one-hot lane", lg_mask[0], 4'b0100);
        chk("R7 block address", lg_addr[0], blk(7,3));
        chk("R7 memory updated", memw[mk(7,3,2)], 32'hBBBB_0001);
        rd_expect("R7 cache updated", mk(7,3,2), 0);
        n_tx = 0;
        access(1'b1, mk(8,0,1), 32'hBBBB_0002, rd);
        chk("R7 miss single write", n_tx, 1);
        chk("R7 miss lane", lg_mask[0], 4'b0010);
        chk("R7 miss memory", memw[mk(8,0,1)], 32'hBBBB_0002);
        rd_expect("R7 no allocate", mk(8,0,1), 1);
        rd_expect("R7 evict other way", mk(9,3,0), 1);
        rd_expect("R7 written line not dirty", mk(10,3,0), 1);
        chk("R7 no write-back", lg_we[0], 0);
        @(negedge clk); wt_mode = 1'b0;
    endtask

    task automatic t_inval;
        logic [31:0] rd;
        access(1'b1, mk(11,2,3), 32'hCCCC_0001, rd);
        n_tx = 0;
        @(negedge clk); cmd_inval = 1'b1;
        @(negedge clk); cmd_inval = 1'b0;
        chk("R10 busy during discard", busy, 1);
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        chk("R8 discard no traffic", n_tx, 0);
        for (int i = 0; i < MEM_WORDS; i++) expw[i] = memw[i];
        chk("R8 dirty data lost", expw[mk(11,2,3)], 32'hC0DE_0000 + mk(11,2,3));
        rd_expect("R8 read after discard", mk(11,2,3), 1);
        rd_expect("R8 old line gone", mk(1,1,0), 1);
    endtask

    task automatic t_flush;
        logic [31:0] rd;
        logic saw_busy, ovl;
        access(1'b1, mk(12,0,0), 32'hDDDD_0001, rd);
        access(1'b1, mk(13,0,1), 32'hDDDD_0002, rd);
        access(1'b1, mk(14,2,2), 32'hDDDD_0003, rd);
        access(1'b0, mk(15,1,0), '0, rd);
        n_tx = 0; saw_busy = 1'b0; ovl = 1'b0;
        @(negedge clk);
        cmd_flush = 1'b1; cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = mk(15,1,0);
        @(negedge clk); cmd_flush = 1'b0;
        for (int i = 0; i < 1000 && !cpu_ready; i++) begin
            if (busy) saw_busy = 1'b1;
            @(negedge clk);
            if (busy && cpu_ready) ovl = 1'b1;
        end
        rd = cpu_rdata; cpu_valid = 1'b0;
        chk("R10 busy seen", saw_busy, 1);
        chk("R10 no ready while busy", ovl, 0);
        chk("R10 pending read data", rd, expw[mk(15,1,0)]);
        chk("R9 transfer count", n_tx, 4);
        chk("R9 first set0 way0", lg_addr[0], blk(12,0));
        chk("R9 second set0 way1", lg_addr[1], blk(13,0));
        chk("R9 third set2 way1", lg_addr[2], blk(14,2));
        chk("R9 writes full lines", {lg_we[2], lg_mask[2]}, 5'h1F);
        chk("R10 pending read after flush", lg_we[3], 0);
        chk("R9 memory P", memw[mk(12,0,0)], 32'hDDDD_0001);
        chk("R9 memory R", memw[mk(14,2,2)], 32'hDDDD_0003);
        rd_expect("R9 invalidated after flush", mk(12,0,0), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_map();
        t_lru();
        t_wb();
        t_wt();
        t_inval();
        t_flush();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule